// File: doc/BRIEF.md
# Grouped GPIO Interrupt Controller

This block watches a set of GPIO input ports and turns them into eight interrupt groups. Each group owns a 4-bit lane select that chooses one pin. For group g the chosen pin is bit g of one 8-pin lane of one port. The selected pin passes through a two-flop synchroniser. A 3-bit trigger code per group then decides whether the group is raised by a level, by an edge, constantly, or not at all.

Edge triggers latch into a sticky pending bit, which software clears by writing ones to an acknowledge register. Level triggers follow the pin and cannot be latched. Pending bits are gated by a per-group enable to form the masked status. The OR of the masked status, registered once, drives a single interrupt line.

Software uses a plain 32-bit register bus with single-cycle writes. A read returns data one cycle after the request, flagged by a valid strobe; there is no back-pressure. After reset every trigger code, lane select and enable is zero, so no group can interrupt.

Top module: `gio_group_irq`

## Requirements
- R1: After reset the trigger, lane-select and enable registers read 0, raw and masked status read 0, and `irq_o` is 0.
- R2: The lane-select field of group g sits at bits 4g+3:4g and holds v = 4*port + lane. The source is pin index port*PORT_W + lane*8 + g of `pins_i`. A value whose port is NUM_PORTS or higher gives a constant 0 source.
- R3: A level change on `pins_i` driven before clock edge P shows in raw status after edge P+1 and on `irq_o` after edge P+2 (two synchroniser flops, one output register).
- R4: In codes 5 (rising), 6 (falling) and 7 (either edge), a matching edge sets the group's pending bit. The bit stays set after the pin returns to its old level.
- R5: In code 1 the pending bit equals the synchronised pin. In code 2 it equals the inverse. An acknowledge write has no lasting effect in either code.
- R6: Code 3 holds the pending bit at 1. Codes 0 and 4 hold it at 0. The trigger field of group g sits at bits 3g+2:3g.
- R7: The enable register bits 7:0 gate the masked status bit by bit. Raw status is not gated.
- R8: Writing the acknowledge register clears the pending edge of every group whose data bit is 1. Bits written as 0 change nothing.
- R9: When an edge event and an acknowledge of the same group fall in the same cycle, the pending bit ends up set.
- R10: `irq_o` equals, one cycle later, the OR of all masked status bits.
- R11: Byte offsets: trigger codes 120, lane select 124, enable 128, acknowledge 132 (write only, reads 0), raw status 136, masked status 140. Each read answers with `bus_rvalid_o` one cycle after `bus_rd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, synchronous |
| bus_wr_i | input | 1 | Write strobe, one word per cycle |
| bus_rd_i | input | 1 | Read request |
| bus_addr_i | input | 8 | Byte address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after bus_rd_i |
| pins_i | input | NUM_PORTS*PORT_W | GPIO input levels, port p at bits p*PORT_W upward |
| irq_o | output | 1 | Combined interrupt request |

## Verification
An acknowledge write and a fresh edge on the same group can land on the same clock edge. There, the clear and the set of the sticky bit compete. The bench arranges this by first leaving group 0 pending, then returning its pin low. It then drives the pin high and issues the acknowledge write two cycles later, so the write is sampled on the same edge as the synchronised event. A masked status of 1 afterwards shows that the event won; a design that lets the clear win reads 0.

// File: rtl/gio_pkg.sv
package gio_pkg;
  localparam int NGROUP  = 8;
  localparam int SEL_W   = 4;
  localparam int CODE_W  = 3;
  localparam int NCAND   = 1 << SEL_W;
  localparam int LANES   = 4;

  localparam logic [7:0] OFS_TRIG  = 8'd120;
  localparam logic [7:0] OFS_LSEL  = 8'd124;
  localparam logic [7:0] OFS_EN    = 8'd128;
  localparam logic [7:0] OFS_ACK   = 8'd132;
  localparam logic [7:0] OFS_RAW   = 8'd136;
  localparam logic [7:0] OFS_MSTAT = 8'd140;

  typedef enum logic [CODE_W-1:0] {
    TRIG_OFF  = 3'd0,
    TRIG_HIGH = 3'd1,
    TRIG_LOW  = 3'd2,
    TRIG_SET  = 3'd3,
    TRIG_RSV  = 3'd4,
    TRIG_RISE = 3'd5,
    TRIG_FALL = 3'd6,
    TRIG_ANY  = 3'd7
  } trig_e;

  function automatic logic code_is_edge(logic [CODE_W-1:0] c);
    return c[2] & (c[1:0] != 2'b00);
  endfunction
endpackage

// File: rtl/gio_regfile.sv
module gio_regfile
  import gio_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic                       rd_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic [NGROUP-1:0]          raw_i,
  input  logic [NGROUP-1:0]          mstat_i,
  output logic [NGROUP*CODE_W-1:0]   trig_o,
  output logic [NGROUP*SEL_W-1:0]    lsel_o,
  output logic [NGROUP-1:0]          en_o,
  output logic [NGROUP-1:0]          ack_o,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       rvalid_o
);
  localparam int TRIG_W = NGROUP * CODE_W;
  localparam int LSEL_W = NGROUP * SEL_W;

  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      trig_o <= '0;
      lsel_o <= '0;
      en_o   <= '0;
    end else if (wr_i) begin
      if (addr_i == OFS_TRIG) trig_o <= wdata_i[TRIG_W-1:0];
      if (addr_i == OFS_LSEL) lsel_o <= wdata_i[LSEL_W-1:0];
      if (addr_i == OFS_EN)   en_o   <= wdata_i[NGROUP-1:0];
    end
  end

  assign ack_o = (wr_i && addr_i == OFS_ACK) ? wdata_i[NGROUP-1:0] : '0;

  always_comb begin
    rd_mux = '0;
    unique case (addr_i)
      OFS_TRIG:  rd_mux[TRIG_W-1:0] = trig_o;
      OFS_LSEL:  rd_mux[LSEL_W-1:0] = lsel_o;
      OFS_EN:    rd_mux[NGROUP-1:0] = en_o;
      OFS_RAW:   rd_mux[NGROUP-1:0] = raw_i;
      OFS_MSTAT: rd_mux[NGROUP-1:0] = mstat_i;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= rd_i;
      if (rd_i) rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/gio_group_lane.sv
module gio_group_lane
  import gio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCAND-1:0]  cand_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  trig_e             code_i,
  input  logic              ack_i,
  output logic              evt_o,
  output logic              raw_o
);
  logic src;
  logic sync1_q, sync2_q, prev_q;
  logic sticky_q;

  assign src = cand_i[sel_i];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sync1_q <= 1'b0;
      sync2_q <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      sync1_q <= src;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  always_comb begin
    unique case (code_i)
      TRIG_RISE: evt_o = sync2_q & ~prev_q;
      TRIG_FALL: evt_o = ~sync2_q & prev_q;
      TRIG_ANY:  evt_o = sync2_q ^ prev_q;
      default:   evt_o = 1'b0;
    endcase
  end

  // event has priority over a same-cycle acknowledge
  always_ff @(posedge clk_i) begin
    if (!rst_ni)                   sticky_q <= 1'b0;
    else if (!code_is_edge(code_i)) sticky_q <= 1'b0;
    else if (evt_o)                sticky_q <= 1'b1;
    else if (ack_i)                sticky_q <= 1'b0;
  end

  always_comb begin
    unique case (code_i)
      TRIG_HIGH: raw_o = sync2_q;
      TRIG_LOW:  raw_o = ~sync2_q;
      TRIG_SET:  raw_o = 1'b1;
      TRIG_RISE, TRIG_FALL, TRIG_ANY: raw_o = sticky_q;
      default:   raw_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/gio_irq_merge.sv
module gio_irq_merge
  import gio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NGROUP-1:0] raw_i,
  input  logic [NGROUP-1:0] en_i,
  output logic [NGROUP-1:0] mstat_o,
  output logic              irq_o
);
  assign mstat_o = raw_i & en_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |mstat_o;
  end
endmodule

// File: rtl/gio_group_irq.sv
module gio_group_irq
  import gio_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        bus_wr_i,
  input  logic                        bus_rd_i,
  input  logic [7:0]                  bus_addr_i,
  input  logic [31:0]                 bus_wdata_i,
  output logic [31:0]                 bus_rdata_o,
  output logic                        bus_rvalid_o,
  input  logic [NUM_PORTS*PORT_W-1:0] pins_i,
  output logic                        irq_o
);
  localparam int NPINS = NUM_PORTS * PORT_W;

  logic [NGROUP*CODE_W-1:0]       trig_w;
  logic [NGROUP*SEL_W-1:0]        lsel_w;
  logic [NGROUP-1:0]              en_w;
  logic [NGROUP-1:0]              ack_w;
  logic [NGROUP-1:0]              evt_w;
  logic [NGROUP-1:0]              raw_w;
  logic [NGROUP-1:0]              mstat_w;
  logic [NGROUP-1:0][NCAND-1:0]   cand_w;

  gio_regfile #(.ADDR_W(8), .DATA_W(32)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (bus_wr_i),
    .rd_i     (bus_rd_i),
    .addr_i   (bus_addr_i),
    .wdata_i  (bus_wdata_i),
    .raw_i    (raw_w),
    .mstat_i  (mstat_w),
    .trig_o   (trig_w),
    .lsel_o   (lsel_w),
    .en_o     (en_w),
    .ack_o    (ack_w),
    .rdata_o  (bus_rdata_o),
    .rvalid_o (bus_rvalid_o)
  );

  for (genvar g = 0; g < NGROUP; g++) begin : g_grp
    for (genvar v = 0; v < NCAND; v++) begin : g_cand
      localparam int PRT = v / LANES;
      localparam int LN  = v % LANES;
      localparam int IDX = PRT * PORT_W + LN * 8 + g;
      if (PRT < NUM_PORTS && (LN * 8 + g) < PORT_W && IDX < NPINS) begin : g_live
        assign cand_w[g][v] = pins_i[IDX];
      end else begin : g_tie
        assign cand_w[g][v] = 1'b0;
      end
    end

    gio_group_lane u_lane (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cand_i (cand_w[g]),
      .sel_i  (lsel_w[g*SEL_W +: SEL_W]),
      .code_i (trig_e'(trig_w[g*CODE_W +: CODE_W])),
      .ack_i  (ack_w[g]),
      .evt_o  (evt_w[g]),
      .raw_o  (raw_w[g])
    );
  end

  gio_irq_merge u_merge (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .raw_i   (raw_w),
    .en_i    (en_w),
    .mstat_o (mstat_w),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/gio_group_irq_chk.sv
module gio_group_irq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [23:0] trig_i,
  input logic [7:0]  en_i,
  input logic [7:0]  ack_i,
  input logic [7:0]  evt_i,
  input logic [7:0]  raw_i,
  input logic [7:0]  mstat_i,
  input logic        irq_i
);
  for (genvar g = 0; g < 8; g++) begin : g_chk
    logic [2:0] code;
    logic       edge_mode;
    assign code      = trig_i[3*g +: 3];
    assign edge_mode = code[2] & (code[1:0] != 2'b00);

    p_ack_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode && ack_i[g] && !evt_i[g]) |=> !raw_i[g]);

    p_event_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (edge_mode && evt_i[g]) |=> (!$stable(trig_i) || raw_i[g]));

    p_set_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code == 3'd3) |-> raw_i[g]);

    p_off_code_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code == 3'd0 || code == 3'd4) |-> !raw_i[g]);
  end

  p_mask_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mstat_i & ~en_i) == 8'h00);

  p_irq_follow_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_i == $past(|mstat_i)));
endmodule

bind gio_group_irq gio_group_irq_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .trig_i  (trig_w),
  .en_i    (en_w),
  .ack_i   (ack_w),
  .evt_i   (evt_w),
  .raw_i   (raw_w),
  .mstat_i (mstat_w),
  .irq_i   (irq_o)
);

// File: tb/test_gio_group_irq.sv
module test_gio_group_irq;
  localparam int CLK_PERIOD = 10;
  localparam int NPORT = 3;
  localparam int PW    = 32;
  localparam logic [7:0] A_TRIG = 8'd120, A_LSEL = 8'd124, A_EN = 8'd128,
                         A_ACK = 8'd132, A_RAW = 8'd136, A_MST = 8'd140;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr = 1'b0, rd = 1'b0;
  logic [7:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic              rvalid;
  logic [NPORT*PW-1:0] pins = '0;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  gio_group_irq #(.NUM_PORTS(NPORT), .PORT_W(PW)) i_gio_group_irq (
    .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_rvalid_o(rvalid), .pins_i(pins), .irq_o(irq)
  );

  // monitor: compare each returned read against the scoreboard
  always @(negedge clk) begin
    if (rvalid) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R11 unexpected read data actual=%h expected=none", rdata);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (rdata !== it.exp) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", it.tag, rdata, it.exp);
        end
      end
    end
  end

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    checks++;
    if (irq !== e) begin
      fails++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
    end
  endtask

  function automatic logic [31:0] tf(input int g, input int c);
    return 32'(c) << (3 * g);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_irq(1'b0, "R1 reset");
    rd_exp(A_TRIG, 32'h0, "R1 trig reset");
    rd_exp(A_LSEL, 32'h0, "R1 lsel reset");
    rd_exp(A_EN,   32'h0, "R1 enable reset");
    rd_exp(A_RAW,  32'h0, "R1 raw reset");
    rd_exp(A_MST,  32'h0, "R1 mstat reset");

    // R11 register layout: g1=6, g2=9, g3=3, g4=5, g7=12
    wr_reg(A_LSEL, 32'hC005_3960);
    rd_exp(A_LSEL, 32'hC005_3960, "R11 lsel readback");
    wr_reg(A_EN, 32'hFF);
    rd_exp(A_EN, 32'hFF, "R11 enable readback");
    rd_exp(A_ACK, 32'h0, "R11 ack reads zero");

    // R4 rising edge, group 0, pin 0
    wr_reg(A_TRIG, tf(0, 5));
    settle();
    rd_exp(A_MST, 32'h0, "R4 rise idle");
    pins[0] = 1'b1; settle();
    rd_exp(A_MST, 32'h01, "R4 rise sets");
    chk_irq(1'b1, "R10 irq on rise");
    pins[0] = 1'b0; settle();
    rd_exp(A_MST, 32'h01, "R4 rise sticky");
    wr_reg(A_ACK, 32'h00); settle();
    rd_exp(A_MST, 32'h01, "R8 zero ack no effect");
    wr_reg(A_ACK, 32'h01); settle();
    rd_exp(A_MST, 32'h00, "R8 ack clears");
    chk_irq(1'b0, "R10 irq after ack");

    // R9 event and acknowledge on the same edge
    pins[0] = 1'b1; settle();
    pins[0] = 1'b0; settle();
    rd_exp(A_MST, 32'h01, "R9 pending before race");
    @(negedge clk); pins[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); wr = 1'b1; addr = A_ACK; wdata = 32'h01;
    @(negedge clk); wr = 1'b0;
    settle();
    rd_exp(A_MST, 32'h01, "R9 event beats ack");
    wr_reg(A_ACK, 32'h01); settle();
    rd_exp(A_MST, 32'h00, "R9 later ack clears");
    pins[0] = 1'b0; settle();

    // R4 falling, group 1, lane sel 6 -> pin 49 (R2)
    wr_reg(A_TRIG, tf(1, 6));
    pins[49] = 1'b1; settle();
    rd_exp(A_RAW, 32'h00, "R4 fall ignores rise");
    pins[49] = 1'b0; settle();
    rd_exp(A_RAW, 32'h02, "R4 fall sets R2 pin49");
    wr_reg(A_ACK, 32'h02); settle();
    rd_exp(A_RAW, 32'h00, "R8 ack fall");

    // R4 either edge, group 2, sel 9 -> pin 74
    wr_reg(A_TRIG, tf(2, 7));
    pins[74] = 1'b1; settle();
    rd_exp(A_RAW, 32'h04, "R4 any rise");
    wr_reg(A_ACK, 32'h04); settle();
    rd_exp(A_RAW, 32'h00, "R8 ack any");
    pins[74] = 1'b0; settle();
    rd_exp(A_RAW, 32'h04, "R4 any fall");
    wr_reg(A_ACK, 32'h04); settle();

    // R5 level high, group 3, sel 3 -> pin 27
    wr_reg(A_TRIG, tf(3, 1)); settle();
    rd_exp(A_RAW, 32'h00, "R5 high idle");
    pins[27] = 1'b1; settle();
    rd_exp(A_RAW, 32'h08, "R5 high follows");
    wr_reg(A_ACK, 32'h08); settle();
    rd_exp(A_RAW, 32'h08, "R5 ack no lasting effect");
    pins[27] = 1'b0; settle();
    rd_exp(A_RAW, 32'h00, "R5 high drops");

    // R3 latency: drive before edge P
    @(negedge clk); pins[27] = 1'b1;
    @(negedge clk); chk_irq(1'b0, "R3 after P");
    @(negedge clk); chk_irq(1'b0, "R3 after P+1");
    @(negedge clk); chk_irq(1'b1, "R3 after P+2");
    pins[27] = 1'b0; settle();
    chk_irq(1'b0, "R10 irq drops");

    // R5 level low, group 4, sel 5 -> pin 44
    wr_reg(A_TRIG, tf(4, 2)); settle();
    rd_exp(A_RAW, 32'h10, "R5 low active");
    pins[44] = 1'b1; settle();
    rd_exp(A_RAW, 32'h00, "R5 low inactive");
    pins[44] = 1'b0;

    // R6 set code, reserved and off codes
    wr_reg(A_TRIG, tf(5, 3)); settle();
    rd_exp(A_RAW, 32'h20, "R6 set code");
    wr_reg(A_ACK, 32'h20); settle();
    rd_exp(A_RAW, 32'h20, "R6 set survives ack");
    wr_reg(A_TRIG, tf(6, 4));
    pins[6] = 1'b1; settle();
    pins[6] = 1'b0; settle();
    rd_exp(A_RAW, 32'h00, "R6 code4 silent");
    pins[7] = 1'b1; settle();
    rd_exp(A_RAW, 32'h00, "R6 code0 silent");
    pins[7] = 1'b0;

    // R7 masking
    wr_reg(A_TRIG, tf(5, 3));
    wr_reg(A_EN, 32'h00); settle();
    rd_exp(A_RAW, 32'h20, "R7 raw ungated");
    rd_exp(A_MST, 32'h00, "R7 masked off");
    chk_irq(1'b0, "R7 irq masked");
    wr_reg(A_EN, 32'h20); settle();
    rd_exp(A_MST, 32'h20, "R7 masked on");
    chk_irq(1'b1, "R7 irq enabled");
    wr_reg(A_EN, 32'hDF); settle();
    rd_exp(A_MST, 32'h00, "R7 other bits");

    // R2 out-of-range port, then a valid lane
    wr_reg(A_EN, 32'hFF);
    wr_reg(A_TRIG, tf(7, 1));
    pins = '1; settle();
    rd_exp(A_RAW, 32'h00, "R2 port3 reads zero");
    wr_reg(A_LSEL, 32'hA000_0000); settle();
    rd_exp(A_RAW, 32'h80, "R2 sel10 pin87 high");
    pins[87] = 1'b0; settle();
    rd_exp(A_RAW, 32'h00, "R2 sel10 pin87 low");

    repeat (4) @(negedge clk);
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R11 reads missing actual=%0d expected=0", sb.size());
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule